// File: doc/BRIEF.md
# Speculative Load Address Log

This block keeps a small associative record of loads that were hoisted above stores whose addresses were unknown at schedule time. When a speculative load issues, the block stores its word address under the load's destination tag. Each later store is compared against every live record, and any record at the same word address is flagged as clobbered. When the matching verify operation arrives, the block decides between two outcomes. If the record is clean, the verify completes silently. If the record is clobbered or missing, the block requests a fresh load and holds the pipeline stalled until memory answers.

Control is a three-state machine. `ST_READY` accepts verify requests. `ST_ISSUE` lasts one cycle and drives the reissue request. `ST_WAIT` holds the stall until the memory response arrives. The transitions are: READY to ISSUE on a verify whose record is clobbered or absent; READY to READY on a clean verify or on no verify; ISSUE to WAIT unconditionally; WAIT to READY when the response arrives; WAIT to WAIT otherwise.

Top module: `spec_load_log`

## Requirements
- R1: After reset, `stall` and `reissue_valid` are low and the table holds no records.
- R2: A speculative load creates a record for its tag. A verify of that tag with no aliasing store in between causes no reissue, and `stall` stays low in the following cycle.
- R3: A store marks every live record whose word address (address bits above bit 1) equals its own. A later verify of a marked tag raises `reissue_valid` in the next cycle, carrying the verify's tag and address. A store to a different word marks nothing.
- R4: `reissue_valid` is a single-cycle pulse in the first stall cycle. `stall` rises together with it and stays high until the cycle after `mem_resp_valid` is seen in `ST_WAIT`.
- R5: A verify frees its record whether or not the record was marked.
- R6: A verify whose tag has no live record is treated as aliased and reissues.
- R7: A speculative load to a tag that already has a record overwrites that record and clears its mark.
- R8: When all slots are live, a speculative load to a new tag evicts a victim. Victims are chosen by a rotating pointer that starts at slot 0 and advances one slot per eviction. Free slots are filled lowest-first.
- R9: A store and a speculative load in the same cycle are ordered store first, so the new record is not marked.
- R10: A store and a verify in the same cycle are ordered store first, so an aliasing store in that cycle causes a reissue.
- R11: A verify presented while `stall` is high is ignored and leaves its record in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spec_valid | input | 1 | Speculative load request |
| spec_tag | input | TAG_W | Destination tag of the speculative load |
| spec_addr | input | ADDR_W | Byte address of the speculative load |
| st_valid | input | 1 | Store request |
| st_addr | input | ADDR_W | Byte address of the store |
| vfy_valid | input | 1 | Verify request |
| vfy_tag | input | TAG_W | Destination tag being verified |
| vfy_addr | input | ADDR_W | Address to reload if reissue is needed |
| mem_resp_valid | input | 1 | Memory response for the reissued load |
| reissue_valid | output | 1 | One-cycle reissue request |
| reissue_tag | output | TAG_W | Tag of the reissued load |
| reissue_addr | output | ADDR_W | Address of the reissued load |
| stall | output | 1 | Pipeline hold |

## Verification
The assertions assume that `mem_resp_valid` is asserted only while the machine waits in `ST_WAIT`, never in the reissue cycle and never when no reissue is pending. The stimulus follows this rule: it raises the response only after it has seen `stall` high with `reissue_valid` already low. Apart from the single deliberate verify used to show that requests are ignored during a stall, the bench presents no other requests while `stall` is high.

// File: rtl/sll_pkg.sv
package sll_pkg;
    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } vfy_state_t;
endpackage

// File: rtl/sll_table.sv
module sll_table #(
    parameter int ENTRIES  = 4,
    parameter int TAG_W    = 5,
    parameter int WA_W     = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lds_v,
    input  logic [TAG_W-1:0] lds_tag,
    input  logic [WA_W-1:0]  lds_wa,
    input  logic             st_v,
    input  logic [WA_W-1:0]  st_wa,
    input  logic             vfy_v,
    input  logic [TAG_W-1:0] vfy_tag,
    output logic             vfy_clean
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic             valid_q [ENTRIES];
    logic             hit_q   [ENTRIES];
    logic [TAG_W-1:0] tag_q   [ENTRIES];
    logic [WA_W-1:0]  wa_q    [ENTRIES];
    logic [IDX_W-1:0] rr_q;

    logic [ENTRIES-1:0] st_hit, lds_hit, vfy_hit, slot_free, slot_clean;
    logic [IDX_W-1:0]   lds_sel;
    logic               lds_evict;

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_slot
            assign st_hit[g]     = st_v && valid_q[g] && (wa_q[g] == st_wa);
            assign lds_hit[g]    = valid_q[g] && (tag_q[g] == lds_tag);
            assign vfy_hit[g]    = valid_q[g] && (tag_q[g] == vfy_tag);
            assign slot_free[g]  = !valid_q[g];
            assign slot_clean[g] = vfy_hit[g] && !hit_q[g] && !st_hit[g];

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    valid_q[g] <= 1'b0;
                    hit_q[g]   <= 1'b0;
                    tag_q[g]   <= '0;
                    wa_q[g]    <= '0;
                end else begin
                    if (st_hit[g])
                        hit_q[g] <= 1'b1;
                    if (vfy_v && vfy_hit[g])
                        valid_q[g] <= 1'b0;
                    if (lds_v && (lds_sel == IDX_W'(g))) begin
                        valid_q[g] <= 1'b1;
                        hit_q[g]   <= 1'b0;
                        tag_q[g]   <= lds_tag;
                        wa_q[g]    <= lds_wa;
                    end
                end
            end
        end
    endgenerate

    // slot choice: existing tag, else lowest free, else rotating victim
    always_comb begin
        lds_sel   = rr_q;
        lds_evict = 1'b1;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (slot_free[i]) begin
                lds_sel   = IDX_W'(i);
                lds_evict = 1'b0;
            end
        end
        for (int i = 0; i < ENTRIES; i++) begin
            if (lds_hit[i]) begin
                lds_sel   = IDX_W'(i);
                lds_evict = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rr_q <= '0;
        else if (lds_v && lds_evict)
            rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end

    assign vfy_clean = |slot_clean;
endmodule

// File: rtl/sll_ctrl.sv
module sll_ctrl
    import sll_pkg::*;
#(
    parameter int TAG_W  = 5,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vfy_req,
    input  logic [TAG_W-1:0]  vfy_tag,
    input  logic [ADDR_W-1:0] vfy_addr,
    input  logic              vfy_clean,
    input  logic              mem_resp_valid,
    output logic              vfy_accept,
    output logic              reissue_valid,
    output logic [TAG_W-1:0]  reissue_tag,
    output logic [ADDR_W-1:0] reissue_addr,
    output logic              stall
);
    vfy_state_t state_q, state_d;
    logic [TAG_W-1:0]  tag_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_READY;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY: if (vfy_req && !vfy_clean) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT:  if (mem_resp_valid) state_d = ST_READY;
            default:  state_d = ST_READY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q  <= '0;
            addr_q <= '0;
        end else if (vfy_accept) begin
            tag_q  <= vfy_tag;
            addr_q <= vfy_addr;
        end
    end

    always_comb begin
        vfy_accept    = 1'b0;
        reissue_valid = 1'b0;
        stall         = 1'b0;
        unique case (state_q)
            ST_READY: vfy_accept = vfy_req;
            ST_ISSUE: begin
                reissue_valid = 1'b1;
                stall         = 1'b1;
            end
            ST_WAIT:  stall = 1'b1;
            default:  stall = 1'b0;
        endcase
    end

    assign reissue_tag  = tag_q;
    assign reissue_addr = addr_q;
endmodule

// File: rtl/spec_load_log.sv
module spec_load_log #(
    parameter int ENTRIES  = 4,
    parameter int TAG_W    = 5,
    parameter int ADDR_W   = 32,
    parameter int WORD_LSB = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spec_valid,
    input  logic [TAG_W-1:0]  spec_tag,
    input  logic [ADDR_W-1:0] spec_addr,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic              vfy_valid,
    input  logic [TAG_W-1:0]  vfy_tag,
    input  logic [ADDR_W-1:0] vfy_addr,
    input  logic              mem_resp_valid,
    output logic              reissue_valid,
    output logic [TAG_W-1:0]  reissue_tag,
    output logic [ADDR_W-1:0] reissue_addr,
    output logic              stall
);
    localparam int WA_W = ADDR_W - WORD_LSB;

    logic vfy_accept, vfy_clean;
    logic unused_lowbits;
    assign unused_lowbits = ^{spec_addr[WORD_LSB-1:0], st_addr[WORD_LSB-1:0]};

    sll_table #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .WA_W(WA_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .lds_v    (spec_valid),
        .lds_tag  (spec_tag),
        .lds_wa   (spec_addr[ADDR_W-1:WORD_LSB]),
        .st_v     (st_valid),
        .st_wa    (st_addr[ADDR_W-1:WORD_LSB]),
        .vfy_v    (vfy_accept),
        .vfy_tag  (vfy_tag),
        .vfy_clean(vfy_clean)
    );

    sll_ctrl #(.TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .vfy_req       (vfy_valid),
        .vfy_tag       (vfy_tag),
        .vfy_addr      (vfy_addr),
        .vfy_clean     (vfy_clean),
        .mem_resp_valid(mem_resp_valid),
        .vfy_accept    (vfy_accept),
        .reissue_valid (reissue_valid),
        .reissue_tag   (reissue_tag),
        .reissue_addr  (reissue_addr),
        .stall         (stall)
    );
endmodule

// File: rtl/spec_load_log_chk.sv
module spec_load_log_chk #(
    parameter int TAG_W  = 5,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              vfy_valid,
    input logic [TAG_W-1:0]  vfy_tag,
    input logic [ADDR_W-1:0] vfy_addr,
    input logic              mem_resp_valid,
    input logic              reissue_valid,
    input logic [TAG_W-1:0]  reissue_tag,
    input logic [ADDR_W-1:0] reissue_addr,
    input logic              stall
);
    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reissue_valid |=> !reissue_valid);

    assert_stall_with_reissue_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reissue_valid |-> stall);

    assert_stall_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !mem_resp_valid) |=> stall);

    assert_stall_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !reissue_valid && mem_resp_valid) |=> !stall);

    assert_reissue_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reissue_valid) |-> (reissue_addr == $past(vfy_addr) && reissue_tag == $past(vfy_tag)));

    assert_ignore_in_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && vfy_valid) |=> !reissue_valid);
endmodule

bind spec_load_log spec_load_log_chk #(.TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .vfy_valid     (vfy_valid),
    .vfy_tag       (vfy_tag),
    .vfy_addr      (vfy_addr),
    .mem_resp_valid(mem_resp_valid),
    .reissue_valid (reissue_valid),
    .reissue_tag   (reissue_tag),
    .reissue_addr  (reissue_addr),
    .stall         (stall)
);

// File: tb/spec_load_log_test.sv
module spec_load_log_test;
    localparam int TAG_W  = 5;
    localparam int ADDR_W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spec_valid = 1'b0, st_valid = 1'b0, vfy_valid = 1'b0, mem_resp_valid = 1'b0;
    logic [TAG_W-1:0]  spec_tag = '0, vfy_tag = '0;
    logic [ADDR_W-1:0] spec_addr = '0, st_addr = '0, vfy_addr = '0;
    logic              reissue_valid, stall;
    logic [TAG_W-1:0]  reissue_tag;
    logic [ADDR_W-1:0] reissue_addr;

    int tests = 0;
    int fails = 0;
    logic [TAG_W+ADDR_W-1:0] exp_q [$];

    always #2 clk = ~clk;

    spec_load_log uut (
        .clk(clk), .rst_n(rst_n),
        .spec_valid(spec_valid), .spec_tag(spec_tag), .spec_addr(spec_addr),
        .st_valid(st_valid), .st_addr(st_addr),
        .vfy_valid(vfy_valid), .vfy_tag(vfy_tag), .vfy_addr(vfy_addr),
        .mem_resp_valid(mem_resp_valid),
        .reissue_valid(reissue_valid), .reissue_tag(reissue_tag),
        .reissue_addr(reissue_addr), .stall(stall)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: every reissue must match the head of the expected queue
    always @(negedge clk) begin
        if (rst_n && reissue_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected reissue", {27'd0, reissue_tag, reissue_addr}, 64'd0);
            end else begin
                logic [TAG_W+ADDR_W-1:0] e;
                e = exp_q.pop_front();
                check({reissue_tag, reissue_addr} == e, "R3 reissue tag/addr",
                      {27'd0, reissue_tag, reissue_addr}, {27'd0, e});
            end
        end
    end

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic lds(input logic [TAG_W-1:0] t, input logic [ADDR_W-1:0] a);
        @(negedge clk); spec_valid = 1'b1; spec_tag = t; spec_addr = a;
        @(negedge clk); spec_valid = 1'b0;
    endtask

    task automatic store(input logic [ADDR_W-1:0] a);
        @(negedge clk); st_valid = 1'b1; st_addr = a;
        @(negedge clk); st_valid = 1'b0;
    endtask

    task automatic lds_and_store(input logic [TAG_W-1:0] t, input logic [ADDR_W-1:0] a);
        @(negedge clk); spec_valid = 1'b1; spec_tag = t; spec_addr = a; st_valid = 1'b1; st_addr = a;
        @(negedge clk); spec_valid = 1'b0; st_valid = 1'b0;
    endtask

    // driver: presents a verify, pushes the expected reissue, serves the response
    task automatic verify(input logic [TAG_W-1:0] t, input logic [ADDR_W-1:0] a,
                          input bit exp_re, input bit with_st, input logic [ADDR_W-1:0] sa,
                          input string req);
        @(negedge clk);
        vfy_valid = 1'b1; vfy_tag = t; vfy_addr = a;
        st_valid = with_st; st_addr = sa;
        if (exp_re) exp_q.push_back({t, a});
        @(negedge clk);
        vfy_valid = 1'b0; st_valid = 1'b0;
        check(stall == exp_re, req, {63'd0, stall}, {63'd0, exp_re});
        check(reissue_valid == exp_re, req, {63'd0, reissue_valid}, {63'd0, exp_re});
        if (exp_re) begin
            @(negedge clk);
            check(stall == 1'b1 && reissue_valid == 1'b0, "R4 wait holds stall",
                  {62'd0, stall, reissue_valid}, 64'd2);
            mem_resp_valid = 1'b1;
            @(negedge clk);
            mem_resp_valid = 1'b0;
            check(stall == 1'b0, "R4 stall released", {63'd0, stall}, 64'd0);
        end
    endtask

    initial begin
        #200000;
        check(1'b0, "watchdog expired", 64'd0, 64'd1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        check(!stall && !reissue_valid, "R1 reset outputs", {62'd0, stall, reissue_valid}, 64'd0);

        // R2 clean verify is a no-op
        lds(5'd1, 32'h1000);
        verify(5'd1, 32'h1000, 1'b0, 1'b0, '0, "R2 clean verify no-op");

        // R3 aliasing store in same word (different byte) marks the record
        lds(5'd2, 32'h2000);
        store(32'h2001);
        verify(5'd2, 32'h2000, 1'b1, 1'b0, '0, "R3 aliased verify reissues");

        // R3 store to a different word leaves record clean
        lds(5'd3, 32'h3000);
        store(32'h3004);
        verify(5'd3, 32'h3000, 1'b0, 1'b0, '0, "R3 other word no mark");

        // R5 record freed after a clean verify -> second verify reissues (R6)
        lds(5'd4, 32'h4000);
        verify(5'd4, 32'h4000, 1'b0, 1'b0, '0, "R5 first verify clean");
        verify(5'd4, 32'h4000, 1'b1, 1'b0, '0, "R5 freed record reissues");

        // R6 unknown tag reissues
        verify(5'd20, 32'h5000, 1'b1, 1'b0, '0, "R6 absent tag reissues");

        // R7 overwrite clears mark
        lds(5'd6, 32'h6000);
        store(32'h6000);
        lds(5'd6, 32'h6100);
        verify(5'd6, 32'h6100, 1'b0, 1'b0, '0, "R7 overwrite clears mark");

        // R9 store and spec load same cycle: not marked
        lds_and_store(5'd7, 32'h7000);
        verify(5'd7, 32'h7000, 1'b0, 1'b0, '0, "R9 store before new record");

        // R10 store and verify same cycle: reissue
        lds(5'd8, 32'h8000);
        verify(5'd8, 32'h8000, 1'b1, 1'b1, 32'h8002, "R10 same-cycle store aliases");

        // R11 verify during stall ignored
        do_reset();
        lds(5'd9, 32'h9000);
        lds(5'd10, 32'hA000);
        store(32'hA000);
        exp_q.push_back({5'd10, 32'hA000});
        @(negedge clk); vfy_valid = 1'b1; vfy_tag = 5'd10; vfy_addr = 32'hA000;
        @(negedge clk); vfy_tag = 5'd9; vfy_addr = 32'h9000;   // still high, now stalled
        check(stall == 1'b1, "R11 stall entered", {63'd0, stall}, 64'd1);
        @(negedge clk); vfy_valid = 1'b0; mem_resp_valid = 1'b1;
        @(negedge clk); mem_resp_valid = 1'b0;
        check(stall == 1'b0, "R11 stall released", {63'd0, stall}, 64'd0);
        verify(5'd9, 32'h9000, 1'b0, 1'b0, '0, "R11 record kept through stall");

        // R8 rotating eviction: fill slots 0..3 with tags 11..14
        do_reset();
        lds(5'd11, 32'hB000);
        lds(5'd12, 32'hB100);
        lds(5'd13, 32'hB200);
        lds(5'd14, 32'hB300);
        lds(5'd15, 32'hB400);   // evicts slot 0 (tag 11)
        lds(5'd16, 32'hB500);   // evicts slot 1 (tag 12)
        verify(5'd11, 32'hB000, 1'b1, 1'b0, '0, "R8 first victim slot 0");
        verify(5'd12, 32'hB100, 1'b1, 1'b0, '0, "R8 second victim slot 1");
        verify(5'd13, 32'hB200, 1'b0, 1'b0, '0, "R8 survivor tag 13");
        verify(5'd14, 32'hB300, 1'b0, 1'b0, '0, "R8 survivor tag 14");
        verify(5'd15, 32'hB400, 1'b0, 1'b0, '0, "R8 new tag 15");
        verify(5'd16, 32'hB500, 1'b0, 1'b0, '0, "R8 new tag 16");

        @(negedge clk);
        check(exp_q.size() == 0, "R3 all expected reissues seen", 64'(exp_q.size()), 64'd0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule